// File: doc/BRIEF.md
# Page-Write Buffer Load Controller

This block handles the write path of a byte-wide nonvolatile memory. The host side is synchronous to `clk_i`. The host strobes bytes in with active-low chip-enable and write-enable. Each byte lands in a page buffer of `PAGE_BYTES` entries, at the offset given by the low address bits.

The load window stays open as long as each new strobe begins soon enough after the previous byte was taken. When the host has been silent for `LOAD_TO_CYC` clocks, the block starts a timed internal write of `WRITE_CYC` clocks. The write cannot be stopped once it has started. At its end, the whole page is committed to a behavioural array:
- The target page is the page address of the last byte loaded.
- Any offset the host never loaded is written as FFh.

While the write runs, a read returns a status byte instead of array data. The data bus is driven only during a chip-enabled, output-enabled read.

Top module: `page_write_ctrl`

## Requirements
- R1: After reset every array byte reads FFh, no write is in progress, and a read returns array data.
- R2: `data_oe_o` is 1 only while both `ce_ni` and `oe_ni` are low. Otherwise it is 0, and the bus is treated as high impedance.
- R3: The address is taken in the cycle where the overlap of `ce_ni` low and `we_ni` low begins, that is, at the later of the two falling edges. The page offset is `addr_i[6:0]`, and the page number is the bits above it.
- R4: The data byte is taken in the cycle where that overlap ends, that is, at the earlier of the two rising edges.
- R5: The load stays open while every new strobe overlap begins within `LOAD_TO_CYC` clocks of the previous data capture, however long the whole load lasts. After `LOAD_TO_CYC` idle clocks, the internal write begins.
- R6: A second byte loaded to an offset that already holds data replaces that byte.
- R7: The page committed is the page of the last byte loaded. Offsets not loaded in this page load are committed as FFh, and the old contents of that page are replaced.
- R8: The internal write lasts `WRITE_CYC` clocks and always runs to completion. Array contents change only at its end.
- R9: A read during the internal write returns a status byte:
  - bit 7 is the inverse of bit 7 of the last byte loaded;
  - bit 6 is 0 on the first read and inverts on each further read;
  - bits 5..0 are 0.
- R10: Strobes that occur during the internal write change neither the buffer nor the target page.
- R11: Each new page load starts with no offsets marked as loaded, so bytes from an earlier page load are never carried into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W (11) | Byte address: page number above a 7-bit offset |
| data_i | input | 8 | Write data from host |
| data_o | output | 8 | Read data or status byte |
| data_oe_o | output | 1 | Bus drive enable for the tri-state buffer |

## Verification
Directed strobe shapes check the capture rules:
- chip-enable falls before write-enable while the address changes in between, which tells the later falling edge from the earlier one;
- the data changes between the two rising edges, which tells the earlier rising edge from the later one.

Directed load sequences check the buffer rules:
- a repeated offset, which separates overwrite from first-wins;
- a final byte on a different page, which shows that the last address picks the page;
- a load spread well beyond the timeout, with short gaps between bytes, which separates a per-byte timeout from a fixed window.

Randomized single-page loads, with random offsets and data, are compared byte for byte against a bench model that fills FFh. Reads taken before, during and after the write tell the status byte apart from array data.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_WRITE = 2'd2
  } pwc_state_e;
endpackage

// File: rtl/pwc_strobe.sv
module pwc_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic we_ni,
  input  logic oe_ni,
  output logic wr_act_o,
  output logic wr_start_o,
  output logic wr_end_o,
  output logic rd_end_o
);
  logic wr_act_q, rd_act_q, rd_act;

  assign wr_act_o = ~ce_ni & ~we_ni;
  assign rd_act   = ~ce_ni & ~oe_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_act_q <= 1'b0;
      rd_act_q <= 1'b0;
    end else begin
      wr_act_q <= wr_act_o;
      rd_act_q <= rd_act;
    end
  end

  // later falling edge starts the overlap, earlier rising edge ends it
  assign wr_start_o = wr_act_o & ~wr_act_q;
  assign wr_end_o   = ~wr_act_o & wr_act_q;
  assign rd_end_o   = ~rd_act & rd_act_q;
endmodule

// File: rtl/pwc_timer.sv
module pwc_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clear_i)               cnt_q <= '0;
    else if (run_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i & ~clear_i & (cnt_q == LAST);
endmodule

// File: rtl/pwc_page_buf.sv
module pwc_page_buf #(
  parameter int unsigned PAGE_BYTES = 128,
  localparam int unsigned OFF_W = $clog2(PAGE_BYTES)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clear_i,
  input  logic                          wr_i,
  input  logic [OFF_W-1:0]              off_i,
  input  logic [7:0]                    data_i,
  output logic [PAGE_BYTES-1:0]         vld_o,
  output logic [PAGE_BYTES-1:0][7:0]    fill_o
);
  logic [PAGE_BYTES-1:0][7:0] buf_q;
  logic [PAGE_BYTES-1:0]      vld_q;

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_byte
    logic hit;
    assign hit = wr_i && (off_i == OFF_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        buf_q[i] <= 8'hFF;
        vld_q[i] <= 1'b0;
      end else if (hit) begin
        buf_q[i] <= data_i;
        vld_q[i] <= 1'b1;
      end else if (clear_i) begin
        vld_q[i] <= 1'b0;
      end
    end

    assign fill_o[i] = vld_q[i] ? buf_q[i] : 8'hFF;
  end

  assign vld_o = vld_q;
endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl
  import pwc_pkg::*;
#(
  parameter int unsigned PAGE_BYTES  = 128,
  parameter int unsigned NUM_PAGES   = 16,
  parameter int unsigned LOAD_TO_CYC = 10000,
  parameter int unsigned WRITE_CYC   = 250000,
  localparam int unsigned OFF_W     = $clog2(PAGE_BYTES),
  localparam int unsigned PG_W      = $clog2(NUM_PAGES),
  localparam int unsigned ADDR_W    = OFF_W + PG_W,
  localparam int unsigned MEM_BYTES = PAGE_BYTES * NUM_PAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  output logic              data_oe_o
);
  pwc_state_e state_q;
  logic wr_act, wr_start, wr_end, rd_end;
  logic [ADDR_W-1:0] addr_q;
  logic addr_ok_q;
  logic [PG_W-1:0] page_q;
  logic [7:0] last_q;
  logic toggle_q;
  logic fire, new_load, load_done, wr_done;
  logic [PAGE_BYTES-1:0]      vld;
  logic [PAGE_BYTES-1:0][7:0] fill;
  logic [7:0] mem_q [MEM_BYTES];

  pwc_strobe u_strobe (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .oe_ni,
    .wr_act_o(wr_act), .wr_start_o(wr_start), .wr_end_o(wr_end), .rd_end_o(rd_end)
  );

  assign fire     = wr_end && addr_ok_q && (state_q != ST_WRITE);
  assign new_load = fire && (state_q == ST_IDLE);

  pwc_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk_i, .rst_ni,
    .clear_i(new_load), .wr_i(fire), .off_i(addr_q[OFF_W-1:0]), .data_i,
    .vld_o(vld), .fill_o(fill)
  );

  pwc_timer #(.LIMIT(LOAD_TO_CYC)) u_load_tmr (
    .clk_i, .rst_ni,
    .clear_i(fire || wr_start || state_q != ST_LOAD),
    .run_i(state_q == ST_LOAD && !wr_act),
    .done_o(load_done)
  );

  pwc_timer #(.LIMIT(WRITE_CYC)) u_write_tmr (
    .clk_i, .rst_ni,
    .clear_i(state_q != ST_WRITE),
    .run_i(state_q == ST_WRITE),
    .done_o(wr_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q    <= '0;
      addr_ok_q <= 1'b0;
    end else if (wr_start) begin
      addr_q    <= addr_i;
      addr_ok_q <= (state_q != ST_WRITE);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      page_q   <= '0;
      last_q   <= 8'hFF;
      toggle_q <= 1'b0;
    end else begin
      if (fire) begin
        page_q <= addr_q[ADDR_W-1:OFF_W];
        last_q <= data_i;
      end
      if (load_done)                           toggle_q <= 1'b0;
      else if (state_q == ST_WRITE && rd_end) toggle_q <= ~toggle_q;
      case (state_q)
        ST_IDLE:  if (fire)      state_q <= ST_LOAD;
        ST_LOAD:  if (load_done) state_q <= ST_WRITE;
        ST_WRITE: if (wr_done)   state_q <= ST_IDLE;
        default:                 state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= 8'hFF;
    end else if (wr_done) begin
      for (int p = 0; p < PAGE_BYTES; p++) mem_q[{page_q, OFF_W'(p)}] <= fill[p];
    end
  end

  assign data_oe_o = ~ce_ni & ~oe_ni;
  assign data_o    = (state_q == ST_WRITE) ? {~last_q[7], toggle_q, 6'b0} : mem_q[addr_i];
endmodule

// File: rtl/pwc_checker.sv
module pwc_checker
  import pwc_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 128
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  ce_ni,
  input logic                  oe_ni,
  input logic                  data_oe_o,
  input pwc_state_e            state_q,
  input logic [PAGE_BYTES-1:0] vld,
  input logic                  toggle_q,
  input logic                  rd_end,
  input logic                  fire,
  input logic                  load_done,
  input logic                  wr_done
);
  a_r2_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni || oe_ni) |-> !data_oe_o);

  a_r8_runs_to_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WRITE && !wr_done) |=> (state_q == ST_WRITE));

  a_r5_write_after_timeout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_WRITE) |-> $past(load_done));

  a_r10_buf_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WRITE) |=> $stable(vld));

  a_r9_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WRITE && rd_end && !wr_done) |=> (toggle_q != $past(toggle_q)));

  a_r11_fresh_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && fire) |=> ($countones(vld) == 1));
endmodule

bind page_write_ctrl pwc_checker #(.PAGE_BYTES(PAGE_BYTES)) u_pwc_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .oe_ni(oe_ni),
  .data_oe_o(data_oe_o), .state_q(state_q), .vld(vld), .toggle_q(toggle_q),
  .rd_end(rd_end), .fire(fire), .load_done(load_done), .wr_done(wr_done)
);

// File: tb/tb_page_write_ctrl.sv
`timescale 1ns/1ps
module tb_page_write_ctrl;
  localparam int PB = 128;
  localparam int NP = 16;
  localparam int LT = 40;
  localparam int WC = 200;
  localparam int AW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic oe_o;

  always #10 clk = ~clk;

  page_write_ctrl #(.PAGE_BYTES(PB), .NUM_PAGES(NP), .LOAD_TO_CYC(LT), .WRITE_CYC(WC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .data_i(wdata), .data_o(rdata), .data_oe_o(oe_o)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] model [PB*NP];
  logic [7:0] pbuf [PB];
  bit pv [PB];
  int ppage;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] status_exp(input logic [7:0] last, input int nread);
    return {~last[7], nread[0], 6'b0};
  endfunction

  task automatic begin_load();
    for (int i = 0; i < PB; i++) pv[i] = 0;
  endtask

  task automatic note(input int a, input logic [7:0] d);
    pbuf[a % PB] = d; pv[a % PB] = 1; ppage = a / PB;
  endtask

  task automatic commit_model();
    for (int i = 0; i < PB; i++) model[ppage*PB + i] = pv[i] ? pbuf[i] : 8'hFF;
  endtask

  task automatic load_byte(input int a, input logic [7:0] d, input bit rec);
    @(negedge clk); addr = AW'(a); wdata = d; ce_n = 0;
    @(negedge clk); we_n = 0;
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1;
    if (rec) note(a, d);
  endtask

  task automatic read_byte(input int a, output logic [7:0] d, output logic e);
    @(negedge clk); addr = AW'(a); ce_n = 0; oe_n = 0;
    @(negedge clk); d = rdata; e = oe_o; ce_n = 1; oe_n = 1;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_page(input int pg, input string req);
    int bad = 0; logic [7:0] d; logic e; int first_a = 0, first_e = 0;
    for (int i = 0; i < PB; i++) begin
      read_byte(pg*PB + i, d, e);
      if (d !== model[pg*PB + i] && bad == 0) begin first_a = d; first_e = model[pg*PB + i]; end
      if (d !== model[pg*PB + i]) bad++;
    end
    check(bad == 0, req, first_a, first_e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d; logic e;
    void'($urandom(32'd2024));
    for (int i = 0; i < PB*NP; i++) model[i] = 8'hFF;
    wait_cyc(3); rst_n = 1; wait_cyc(2);

    // R1 reset state and R2 bus control
    read_byte(300, d, e);
    check(d == 8'hFF, "R1 reset array", d, 8'hFF);
    check(e == 1'b1, "R2 oe on read", e, 1);
    @(negedge clk); ce_n = 0; oe_n = 1; @(negedge clk);
    check(oe_o == 1'b0, "R2 hiz oe high", oe_o, 0);
    ce_n = 1; oe_n = 0; @(negedge clk);
    check(oe_o == 1'b0, "R2 hiz ce high", oe_o, 0);
    oe_n = 1;

    // R3 later falling edge, R4 earlier rising edge, R6 overwrite
    begin_load();
    @(negedge clk); addr = AW'(2*PB + 9); wdata = 8'h11; ce_n = 0;
    @(negedge clk); addr = AW'(2*PB + 5); we_n = 0;
    @(negedge clk); wdata = 8'h3C;
    @(negedge clk); we_n = 1;
    @(negedge clk); wdata = 8'hC3; ce_n = 1;
    note(2*PB + 5, 8'h3C);
    load_byte(2*PB + 7, 8'h11, 1);
    load_byte(2*PB + 7, 8'h22, 1);
    wait_cyc(LT + 10);
    // R9 status during write
    read_byte(2*PB + 5, d, e);
    check(d == status_exp(8'h22, 0), "R9 first status", d, status_exp(8'h22, 0));
    read_byte(2*PB + 5, d, e);
    check(d == status_exp(8'h22, 1), "R9 toggled status", d, status_exp(8'h22, 1));
    // R10 load during write ignored
    load_byte(2*PB + 20, 8'h55, 0);
    wait_cyc(WC - 40);
    read_byte(2*PB + 5, d, e);
    check(d[5:0] == 6'b0 && d[7] == 1'b1, "R8 still busy", d, 8'h80);
    wait_cyc(40);
    commit_model();
    read_byte(2*PB + 5, d, e);
    check(d == 8'h3C, "R3 R4 latch edges", d, 8'h3C);
    read_byte(2*PB + 7, d, e);
    check(d == 8'h22, "R6 overwrite", d, 8'h22);
    read_byte(2*PB + 20, d, e);
    check(d == 8'hFF, "R10 ignored load", d, 8'hFF);
    check_page(2, "R7 fill page 2");

    // R7 last byte picks page
    begin_load();
    load_byte(4*PB + 1, 8'hAA, 1);
    load_byte(6*PB + 2, 8'h9A, 1);
    wait_cyc(LT + WC + 20);
    commit_model();
    check_page(6, "R7 last page");
    check_page(4, "R7 other page untouched");

    // R5 long load kept open by short gaps
    begin_load();
    for (int k = 0; k < 5; k++) begin
      load_byte(8*PB + 10*k, 8'(8'h90 + k), 1);
      if (k < 4) wait_cyc(LT - 10);
    end
    load_byte(8*PB + 100, 8'h9A, 1);
    wait_cyc(LT - 15);
    read_byte(8*PB + 100, d, e);
    check(d == 8'hFF, "R5 window still open", d, 8'hFF);
    wait_cyc(30);
    read_byte(8*PB + 100, d, e);
    check(d == status_exp(8'h9A, 0), "R5 write after timeout", d, status_exp(8'h9A, 0));
    wait_cyc(WC);
    commit_model();
    check_page(8, "R5 committed");

    // R11 fresh load on page 2 forgets earlier bytes
    begin_load();
    load_byte(2*PB + 7, 8'h44, 1);
    wait_cyc(LT + WC + 20);
    commit_model();
    read_byte(2*PB + 5, d, e);
    check(d == 8'hFF, "R11 old offset refilled", d, 8'hFF);
    check_page(2, "R11 page 2");

    // random single-page loads
    for (int it = 0; it < 6; it++) begin
      int pg = int'($urandom % NP);
      int n = 1 + int'($urandom % 8);
      begin_load();
      for (int k = 0; k < n; k++) begin
        load_byte(pg*PB + int'($urandom % 16), 8'($urandom), 1);
        wait_cyc(int'($urandom % 20));
      end
      wait_cyc(LT + WC + 20);
      commit_model();
      check_page(pg, "R7 random page");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule